// File: doc/BRIEF.md
# Two-Bank Configurable Signal Crossbar

This block is a software-configured routing switch between two banks of bidirectional pins, bank A and bank B, with 11 pins each. Each pin has a small configuration cell. The cell makes the pin one of three things. It can be an input. It can be an output held at a constant level. It can be an output that copies one chosen pin of the other bank, either true or inverted. Routing only crosses between the banks. A single input pin can feed any number of outputs on the other side, so one signal such as a clock can be fanned out to several pins.

The block does not drive the pads itself. For every pin it receives the pad's input value and returns an output value and an output enable, which go to external tri-state pad cells.

Configuration is loaded through a serial shift port clocked by the system clock, with a shift enable, a data input, a data output and a latch strobe. Bits go into a shadow chain. On a latch strobe the whole shadow chain is copied into the active configuration in one cycle, so the pins never show a half-loaded setup. While new bits are shifted in, the old shadow contents come out of the data output, which lets software read back and verify what it loaded.

Top module: `xbar2_top`

## Requirements
- R1: After reset every output enable and output value is 0, the error flag is 0 and the serial output is 0. All cells stay in input mode until the first latch strobe.
- R2: The shadow chain is 154 bits: 22 cells of 7 bits each, shifted in MSB first.
  - Each cell is laid out as bit 6 = C0, bit 5 = C1, bit 4 = C2 (invert), bits 3..0 = source index.
  - Cell k sits at chain bits [7k+6:7k]. Cells 0..10 are A0..A10 and cells 11..21 are B0..B10.
  - The first bit shifted in ends up at chain bit 153.
- R3: The serial output always presents chain bit 153. A full 154-bit shift therefore returns the previous shadow contents in the same order they were sent.
- R4: The active configuration changes only on a latch strobe and takes effect in the following cycle. Shifting without a latch leaves all pin outputs unchanged.
- R5: With {C0,C1}=00 the pin is an input: its output enable is 0 and its output value is 0.
- R6: With {C0,C1}=11 the pin drives 1, and with {C0,C1}=01 it drives 0. In both cases the output enable is 1 and C2 has no effect.
- R7: With {C0,C1}=10 the pin drives the opposite-bank pin chosen by the source index, XOR C2, with the output enable at 1. Pins of its own bank have no effect on it.
- R8: Several routed outputs may select the same source pin, and each follows that pin with its own polarity.
- R9: A routed output whose source pin is not in input mode drives 0.
- R10: A routed output with a source index above 10 drives 0. One cycle after such a configuration becomes active, the error flag sets, and it stays set until reset.
- R11: When a latch and a shift occur in the same cycle, the active configuration takes the shadow contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift enable for the shadow chain |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_latch | input | 1 | Copy shadow chain to active configuration |
| cfg_sdo | output | 1 | Serial data out (chain MSB) |
| a_in | input | 11 | Pad input values, bank A |
| a_out | output | 11 | Output values, bank A |
| a_oe | output | 11 | Output enables, bank A |
| b_in | input | 11 | Pad input values, bank B |
| b_out | output | 11 | Output values, bank B |
| b_oe | output | 11 | Output enables, bank B |
| err_flag | output | 1 | Sticky flag for an out-of-range source index |

## Verification
The bench loads several configurations and checks the pins against a behavioural model under varied pad patterns. It uses pin patterns where one source feeds two outputs of opposite polarity, so that crossed or missing inversion is exposed. It also toggles same-bank pins, so that a design that routes within a bank is caught. It checks the window between a shift and its latch: a design that applies the chain early would change the pins in that window. It also drives a latch and a shift in the same cycle, which exposes a design that captures the post-shift chain. Further cases cover:
- a routed pin whose source is itself an output, which a design missing the input-only rule would echo;
- a source index of 12, which must give a low pin and a flag that stays set after a clean reload;
- read-back of the chain, which reveals a wrong bit order or a wrong tap position.

// File: rtl/xbar2_pkg.sv
package xbar2_pkg;
    localparam int BANK_W_DEF = 11;
    localparam int SRC_W      = 4;
    localparam int CELL_W     = 3 + SRC_W;

    // Mode code is {C0,C1}
    typedef enum logic [1:0] {
        MODE_IN    = 2'b00,
        MODE_LOW   = 2'b01,
        MODE_ROUTE = 2'b10,
        MODE_HIGH  = 2'b11
    } mode_e;

    typedef struct packed {
        logic             c0;
        logic             c1;
        logic             inv;
        logic [SRC_W-1:0] src;
    } cell_cfg_t;

    function automatic mode_e mode_of(input cell_cfg_t c);
        return mode_e'({c.c0, c.c1});
    endfunction
endpackage

// File: rtl/xbar2_cfg_chain.sv
module xbar2_cfg_chain #(
    parameter int CHAIN_W = 154
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               latch,
    output logic               sdo,
    output logic [CHAIN_W-1:0] active
);
    typedef struct packed {
        logic [CHAIN_W-1:0] shadow;
        logic [CHAIN_W-1:0] live;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.shadow = {st_q.shadow[CHAIN_W-2:0], sdi};
        end
        // latch copies the chain as it was before any shift in this cycle
        if (latch) begin
            st_d.live = st_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo    = st_q.shadow[CHAIN_W-1];
    assign active = st_q.live;
endmodule

// File: rtl/xbar2_cell.sv
module xbar2_cell
    import xbar2_pkg::*;
#(
    parameter int BANK_W = BANK_W_DEF
) (
    input  cell_cfg_t         cfg,
    input  logic [BANK_W-1:0] opp_in,
    input  logic [BANK_W-1:0] opp_is_input,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              src_bad
);
    logic src_hit;
    logic src_val;
    logic src_ok;

    always_comb begin
        src_hit = 1'b0;
        src_val = 1'b0;
        src_ok  = 1'b0;
        for (int j = 0; j < BANK_W; j++) begin
            if (cfg.src == SRC_W'(j)) begin
                src_hit = 1'b1;
                src_val = opp_in[j];
                src_ok  = opp_is_input[j];
            end
        end
    end

    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        src_bad = 1'b0;
        unique case (mode_of(cfg))
            MODE_IN: begin
                pin_oe  = 1'b0;
                pin_out = 1'b0;
            end
            MODE_LOW: begin
                pin_oe  = 1'b1;
                pin_out = 1'b0;
            end
            MODE_HIGH: begin
                pin_oe  = 1'b1;
                pin_out = 1'b1;
            end
            MODE_ROUTE: begin
                pin_oe  = 1'b1;
                src_bad = !src_hit;
                pin_out = (src_hit && src_ok) ? (src_val ^ cfg.inv) : 1'b0;
            end
            default: begin
                pin_oe  = 1'b0;
                pin_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xbar2_top.sv
module xbar2_top
    import xbar2_pkg::*;
#(
    parameter int BANK_W = BANK_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift,
    input  logic              cfg_sdi,
    input  logic              cfg_latch,
    output logic              cfg_sdo,
    input  logic [BANK_W-1:0] a_in,
    output logic [BANK_W-1:0] a_out,
    output logic [BANK_W-1:0] a_oe,
    input  logic [BANK_W-1:0] b_in,
    output logic [BANK_W-1:0] b_out,
    output logic [BANK_W-1:0] b_oe,
    output logic              err_flag
);
    localparam int NCELL   = 2 * BANK_W;
    localparam int CHAIN_W = NCELL * CELL_W;

    typedef struct packed {
        logic err;
    } top_st_t;

    logic [CHAIN_W-1:0] act_flat;
    cell_cfg_t          cell_cfg [NCELL];
    logic [NCELL-1:0]   is_in;
    logic [NCELL-1:0]   bad;
    logic [NCELL-1:0]   out_all;
    logic [NCELL-1:0]   oe_all;
    top_st_t            st_d, st_q;

    xbar2_cfg_chain #(.CHAIN_W(CHAIN_W)) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .sdi      (cfg_sdi),
        .latch    (cfg_latch),
        .sdo      (cfg_sdo),
        .active   (act_flat)
    );

    for (genvar k = 0; k < NCELL; k++) begin : g_unpack
        assign cell_cfg[k] = cell_cfg_t'(act_flat[k*CELL_W +: CELL_W]);
        assign is_in[k]    = (mode_of(cell_cfg[k]) == MODE_IN);
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_bank
        xbar2_cell #(.BANK_W(BANK_W)) a_cell_i (
            .cfg          (cell_cfg[i]),
            .opp_in       (b_in),
            .opp_is_input (is_in[NCELL-1:BANK_W]),
            .pin_out      (out_all[i]),
            .pin_oe       (oe_all[i]),
            .src_bad      (bad[i])
        );
        xbar2_cell #(.BANK_W(BANK_W)) b_cell_i (
            .cfg          (cell_cfg[BANK_W+i]),
            .opp_in       (a_in),
            .opp_is_input (is_in[BANK_W-1:0]),
            .pin_out      (out_all[BANK_W+i]),
            .pin_oe       (oe_all[BANK_W+i]),
            .src_bad      (bad[BANK_W+i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err | (|bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out    = out_all[BANK_W-1:0];
    assign a_oe     = oe_all[BANK_W-1:0];
    assign b_out    = out_all[NCELL-1:BANK_W];
    assign b_oe     = oe_all[NCELL-1:BANK_W];
    assign err_flag = st_q.err;
endmodule

// File: rtl/xbar2_chk.sv
module xbar2_chk
    import xbar2_pkg::*;
#(
    parameter int BANK_W = BANK_W_DEF
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_shift,
    input logic                           cfg_latch,
    input logic                           cfg_sdo,
    input logic [2*BANK_W*CELL_W-1:0]     act_flat,
    input logic [BANK_W-1:0]              a_oe,
    input logic [BANK_W-1:0]              b_oe,
    input logic                           err_flag
);
    localparam int NCELL = 2 * BANK_W;
    logic [2*BANK_W-1:0] oe_all;
    assign oe_all = {b_oe, a_oe};

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (a_oe == '0 && b_oe == '0 && !err_flag))
        else $error("reset state not idle"); // R1

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_sdo))
        else $error("serial out moved without shift"); // R3

    AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_latch |=> $stable(act_flat))
        else $error("active config changed without latch"); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag)
        else $error("error flag cleared"); // R10

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (act_flat[k*CELL_W+CELL_W-1 -: 2] == 2'b00) |-> !oe_all[k])
            else $error("input-mode pin enabled"); // R5

        AST_BAD_SRC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ((act_flat[k*CELL_W+CELL_W-1 -: 2] == 2'b10) &&
             (act_flat[k*CELL_W +: SRC_W] >= SRC_W'(BANK_W))) |=> err_flag)
            else $error("bad source not flagged"); // R10
    end
endmodule

bind xbar2_top xbar2_chk #(.BANK_W(BANK_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_latch (cfg_latch),
    .cfg_sdo   (cfg_sdo),
    .act_flat  (act_flat),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .err_flag  (err_flag)
);

// File: tb/xbar2_top_tb_top.sv
module xbar2_top_tb_top;
    localparam int BW = 11;
    localparam int NC = 2 * BW;
    localparam int CW = 7;
    localparam int LW = NC * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shift = 1'b0, cfg_sdi = 1'b0, cfg_latch = 1'b0;
    logic cfg_sdo;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;
    logic err_flag;

    always #4 clk = ~clk;

    xbar2_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
        .cfg_latch(cfg_latch), .cfg_sdo(cfg_sdo),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .err_flag(err_flag)
    );

    typedef struct {
        string         req;
        logic [BW-1:0] ao, aoe, bo, boe;
        logic          err;
    } exp_t;

    exp_t   sb_q[$];
    event   mon_ev;
    int     total = 0;
    int     bad = 0;
    logic [CW-1:0] cfg_tb [NC];
    logic [CW-1:0] act_tb [NC];
    logic          err_tb = 1'b0;

    // model of the pins from the requirements
    task automatic model(output logic [BW-1:0] ao, aoe, bo, boe, output logic badsrc);
        ao = '0; aoe = '0; bo = '0; boe = '0; badsrc = 1'b0;
        for (int k = 0; k < NC; k++) begin
            logic [CW-1:0] c;
            logic o, e;
            int base;
            logic [BW-1:0] opp;
            c = act_tb[k];
            base = (k < BW) ? BW : 0;
            opp  = (k < BW) ? b_in : a_in;
            o = 1'b0; e = 1'b0;
            case (c[6:5])
                2'b00: begin e = 1'b0; o = 1'b0; end
                2'b11: begin e = 1'b1; o = 1'b1; end
                2'b01: begin e = 1'b1; o = 1'b0; end
                default: begin
                    e = 1'b1;
                    if (int'(c[3:0]) > BW - 1) begin
                        o = 1'b0; badsrc = 1'b1;
                    end else if (act_tb[base + int'(c[3:0])][6:5] != 2'b00) begin
                        o = 1'b0;
                    end else begin
                        o = opp[c[3:0]] ^ c[4];
                    end
                end
            endcase
            if (k < BW) begin ao[k] = o; aoe[k] = e; end
            else begin bo[k-BW] = o; boe[k-BW] = e; end
        end
    endtask

    function automatic logic [LW-1:0] pack_cfg();
        logic [LW-1:0] v;
        for (int k = 0; k < NC; k++) v[k*CW +: CW] = cfg_tb[k];
        return v;
    endfunction

    task automatic clear_cfg();
        for (int k = 0; k < NC; k++) cfg_tb[k] = '0;
    endtask

    // driver: push expected pin state, monitor compares
    task automatic push_exp(input string req);
        exp_t it;
        logic b;
        it.req = req;
        model(it.ao, it.aoe, it.bo, it.boe, b);
        it.err = err_tb;
        sb_q.push_back(it);
        ->mon_ev;
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            exp_t it;
            @(mon_ev);
            #1;
            it = sb_q.pop_front();
            total++;
            if (a_out !== it.ao || a_oe !== it.aoe || b_out !== it.bo ||
                b_oe !== it.boe || err_flag !== it.err) begin
                bad++;
                $display("FAIL %s: got a=%h/%h b=%h/%h err=%b exp a=%h/%h b=%h/%h err=%b",
                         it.req, a_out, a_oe, b_out, b_oe, err_flag,
                         it.ao, it.aoe, it.bo, it.boe, it.err);
            end
        end
    end

    task automatic check_bits(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", req, act, exp);
        end
    endtask

    task automatic shift_all(input logic [LW-1:0] v, output logic [LW-1:0] rb);
        for (int i = LW - 1; i >= 0; i--) begin
            cfg_sdi   = v[i];
            cfg_shift = 1'b1;
            rb[i]     = cfg_sdo;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
    endtask

    task automatic update_err();
        logic [BW-1:0] x0, x1, x2, x3;
        logic b;
        model(x0, x1, x2, x3, b);
        err_tb = err_tb | b;
    endtask

    task automatic do_latch();
        cfg_latch = 1'b1;
        @(negedge clk);
        cfg_latch = 1'b0;
        for (int k = 0; k < NC; k++) act_tb[k] = cfg_tb[k];
        @(negedge clk);
        update_err();
    endtask

    task automatic pin_patterns(input string req);
        a_in = '0;       b_in = '0;       push_exp(req);
        a_in = '1;       b_in = '0;       push_exp(req);
        a_in = '0;       b_in = 11'h008;  push_exp(req);
        a_in = 11'h5A5;  b_in = 11'h2AA;  push_exp(req);
        a_in = 11'h7DF;  b_in = 11'h7F7;  push_exp(req);
    endtask

    initial begin : stim
        logic [LW-1:0] rb, img1, img3;
        clear_cfg();
        for (int k = 0; k < NC; k++) act_tb[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R1 reset outputs");
        total++;
        if (cfg_sdo !== 1'b0) begin
            bad++; $display("FAIL R1 sdo: got %b exp 0", cfg_sdo);
        end

        // configuration 1
        clear_cfg();
        cfg_tb[0]    = 7'b100_0011; // A0 <- B3
        cfg_tb[1]    = 7'b101_0011; // A1 <- ~B3 (fanout R8)
        cfg_tb[2]    = 7'b110_0000; // A2 high
        cfg_tb[3]    = 7'b011_0000; // A3 low, C2 set (R6)
        cfg_tb[BW+0] = 7'b100_0101; // B0 <- A5
        cfg_tb[BW+6] = 7'b111_0000; // B6 high with C2
        cfg_tb[BW+8] = 7'b101_0000; // B8 <- ~A0
        img1 = pack_cfg();
        shift_all(img1, rb);
        check_bits("R3 readback of reset chain", rb, '0);
        a_in = '1; b_in = '1;
        push_exp("R4 no change before latch");
        do_latch();
        pin_patterns("R5 R6 R7 R8 routing");
        a_in = 11'h000; b_in = 11'h008;
        push_exp("R7 same bank baseline");
        a_in = 11'h000; b_in = 11'h7F7;
        push_exp("R7 same-bank change ignored");

        // configuration 2
        clear_cfg();
        cfg_tb[2]    = 7'b110_0000; // A2 high
        cfg_tb[7]    = 7'b101_1001; // A7 <- ~B9
        cfg_tb[BW+1] = 7'b100_0010; // B1 <- A2 (output) R9
        cfg_tb[BW+2] = 7'b101_1100; // B2 src 12 R10
        shift_all(pack_cfg(), rb);
        check_bits("R2 R3 readback of config 1", rb, img1);
        do_latch();
        pin_patterns("R9 R10 source rules");

        // configuration 3, clean; flag must stay
        clear_cfg();
        cfg_tb[BW-1] = 7'b100_1010; // A10 <- B10
        cfg_tb[NC-1] = 7'b101_0000; // B10 <- ~A0
        cfg_tb[4]    = 7'b011_0000; // A4 low
        img3 = pack_cfg();
        shift_all(img3, rb);
        // shift and latch together: active takes pre-shift chain (R11)
        cfg_sdi = 1'b1; cfg_shift = 1'b1; cfg_latch = 1'b1;
        @(negedge clk);
        cfg_shift = 1'b0; cfg_latch = 1'b0;
        for (int k = 0; k < NC; k++) act_tb[k] = cfg_tb[k];
        @(negedge clk);
        update_err();
        pin_patterns("R11 R10 latch with shift, sticky flag");

        // shift without latch: pins unchanged (R4)
        clear_cfg();
        cfg_tb[0] = 7'b110_0000;
        shift_all(pack_cfg(), rb);
        check_bits("R11 R3 readback after combined cycle", rb, {img3[LW-2:0], 1'b1});
        pin_patterns("R4 shift without latch");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule